// File: doc/BRIEF.md
# CAN Interframe Space and Overload Controller

This block takes over the bus each time a frame finishes. It counts the intermission bits that must follow every frame. It decides what a dominant bit seen in that window means. It drives overload frames onto the transmit line when needed. When nothing happens it reports an idle bus, and when a new frame begins it reports a start of frame. The frame decoder pulses `frame_end` when a frame closes. The bit timing logic pulses `bit_tick` once per bit, at the moment `rx_bit` holds the sampled bus level. Bus levels are encoded as 0 for dominant and 1 for recessive.

An overload frame has two causes. The first is a dominant bit in the first or second intermission bit. The second is the local receive path raising `local_busy` to ask for more time before the next frame. Locally requested overload frames are capped at two in a row. The cap clears whenever a start of frame is seen.

There is no streaming data path. All pins are plain control and status signals with no back-pressure. A pulse on `frame_end` or `bit_tick` is acted on in the clock cycle it is high. The outputs reflect the result from the following clock cycle.

Top module: `can_ifs_ovl_ctrl`

## Requirements
- R1: After reset, `tx_bit` is 1 (recessive), `sof_pulse`, `bus_idle` and `ovl_active` are 0, and the block waits for `frame_end`.
- R2: After `frame_end`, if three bit ticks each sample `rx_bit`=1 and no local overload is granted, `bus_idle` goes high after the third tick and stays high.
- R3: A tick that samples `rx_bit`=0 in the first or second intermission bit starts an overload frame. `ovl_active` rises, and `tx_bit` is 0 for exactly the next six bit ticks, then returns to 1.
- R4: A tick that samples `rx_bit`=0 in the third intermission bit gives a one-cycle `sof_pulse` and starts no overload. The block then waits for `frame_end`.
- R5: While `bus_idle` is high, a tick that samples `rx_bit`=0 gives a one-cycle `sof_pulse` and drops `bus_idle`. The block then waits for `frame_end`.
- R6: After its own six-bit flag, the block tolerates dominant bits from other nodes, up to twelve dominant bits in total. The first recessive bit counts as delimiter bit one. After the eighth recessive bit, `ovl_active` falls and the intermission restarts from its first bit.
- R7: A thirteenth consecutive dominant bit, or a dominant bit inside the delimiter, abandons the overload frame. `ovl_active` falls, no `sof_pulse` is given, and the block waits for `frame_end`.
- R8: If the third intermission bit is recessive and `local_busy` is 1, an overload frame starts instead of the idle state. This happens at most twice in a row. On the next such request the block goes idle.
- R9: A start of frame clears the count of locally requested overload frames.
- R10: `frame_end` has effect only while the block waits for it. `rx_bit` has effect only on a bit tick. An overload frame only ever starts out of the intermission.
- R11: `tx_bit` is 0 only while the overload flag is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end | input | 1 | One-cycle pulse when a frame has ended |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| local_busy | input | 1 | Local request to delay the next frame |
| tx_bit | output | 1 | Transmit level, 0 dominant, 1 recessive |
| sof_pulse | output | 1 | One-cycle pulse when a start of frame is recognised |
| bus_idle | output | 1 | High while the bus is idle after the intermission |
| ovl_active | output | 1 | High during an overload frame |

## Verification
A wrong bit count in the sequencer shows up on `tx_bit` or `ovl_active`. It appears one clock after the bit tick on which the flag or delimiter should have ended. A mistaken intermission position is visible at once, on the tick that samples the dominant bit: either a spurious flag appears or `sof_pulse` is missing. A broken local-request cap hides until the third back-to-back request, where `bus_idle` fails to rise. Failing to clear that cap shows on the first request after a start of frame.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;
  typedef enum logic [2:0] {
    S_WAIT_END,
    S_INTER,
    S_IDLE,
    S_FLAG,
    S_ECHO,
    S_DELIM
  } ifs_state_e;
endpackage

// File: rtl/ifs_bit_cnt.sv
module ifs_bit_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end

  // the sequencer must never run a field counter into wraparound (R6)
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (q != '1));
endmodule

// File: rtl/ifs_local_limiter.sv
module ifs_local_limiter #(
  parameter int MAX_LOCAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  output logic ok
);
  localparam int LW = $clog2(MAX_LOCAL + 1);
  localparam logic [LW-1:0] CAP = LW'(MAX_LOCAL);

  logic [LW-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             used_q <= '0;
    else if (clr)           used_q <= '0;
    else if (take && ok)    used_q <= used_q + LW'(1);
  end

  assign ok = (used_q < CAP);

  // back-to-back local overload frames never exceed the cap (R8)
  p_local_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CAP);
  // a start of frame empties the count (R9)
  p_clear_on_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (used_q == '0));
endmodule

// File: rtl/ifs_seq.sv
module ifs_seq
  import can_ifs_pkg::*;
#(
  parameter int INTER_BITS   = 3,
  parameter int FLAG_BITS    = 6,
  parameter int DELIM_BITS   = 8,
  parameter int MAX_DOM_BITS = 12,
  parameter int CW           = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          bit_tick,
  input  logic          rx_bit,
  input  logic          local_busy,
  input  logic          local_ok,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          local_take,
  output logic          sof_seen,
  output ifs_state_e    state,
  output logic          sof_pulse
);
  localparam logic [CW-1:0] INTER_LAST = CW'(INTER_BITS - 1);
  localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_BITS - 1);
  localparam logic [CW-1:0] ECHO_LIM   = CW'(MAX_DOM_BITS - FLAG_BITS);
  localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 2);

  ifs_state_e nxt;

  always_comb begin
    nxt        = state;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    local_take = 1'b0;
    sof_seen   = 1'b0;
    case (state)
      S_WAIT_END: begin
        if (frame_end) begin
          nxt     = S_INTER;
          cnt_clr = 1'b1;
        end
      end
      S_INTER: begin
        if (bit_tick) begin
          if (!rx_bit) begin
            cnt_clr = 1'b1;
            if (cnt == INTER_LAST) begin
              sof_seen = 1'b1;
              nxt      = S_WAIT_END;
            end else begin
              nxt = S_FLAG;
            end
          end else if (cnt == INTER_LAST) begin
            cnt_clr = 1'b1;
            if (local_busy && local_ok) begin
              nxt        = S_FLAG;
              local_take = 1'b1;
            end else begin
              nxt = S_IDLE;
            end
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      S_IDLE: begin
        if (bit_tick && !rx_bit) begin
          sof_seen = 1'b1;
          nxt      = S_WAIT_END;
        end
      end
      S_FLAG: begin
        if (bit_tick) begin
          if (cnt == FLAG_LAST) begin
            nxt     = S_ECHO;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      S_ECHO: begin
        if (bit_tick) begin
          if (rx_bit) begin
            nxt     = S_DELIM;
            cnt_clr = 1'b1;
          end else if (cnt == ECHO_LIM) begin
            nxt     = S_WAIT_END;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      S_DELIM: begin
        if (bit_tick) begin
          if (!rx_bit) begin
            nxt     = S_WAIT_END;
            cnt_clr = 1'b1;
          end else if (cnt == DELIM_LAST) begin
            nxt     = S_INTER;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: nxt = S_WAIT_END;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_WAIT_END;
      sof_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      sof_pulse <= sof_seen;
    end
  end

  // start of frame is a single-cycle indication (R4)
  p_sof_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);
  // SOF only follows a bit tick in the third intermission bit or idle (R5)
  p_sof_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> ($past(bit_tick) && !$past(rx_bit)
                   && ($past(state) == S_INTER || $past(state) == S_IDLE)));
  // an overload flag is only ever entered from the intermission (R10)
  p_flag_from_inter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLAG && $past(state) != S_FLAG) |-> ($past(state) == S_INTER));
  // without a tick or frame end nothing moves (R10)
  p_hold_without_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !frame_end) |=> $stable(state));
  // idle is reached only from a recessive intermission bit (R2)
  p_idle_from_inter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) != S_IDLE)
      |-> ($past(state) == S_INTER && $past(rx_bit)));
endmodule

// File: rtl/can_ifs_ovl_ctrl.sv
module can_ifs_ovl_ctrl
  import can_ifs_pkg::*;
#(
  parameter int INTER_BITS   = 3,
  parameter int FLAG_BITS    = 6,
  parameter int DELIM_BITS   = 8,
  parameter int MAX_DOM_BITS = 12,
  parameter int MAX_LOCAL    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic local_busy,
  output logic tx_bit,
  output logic sof_pulse,
  output logic bus_idle,
  output logic ovl_active
);
  localparam int CW = $clog2(MAX_DOM_BITS + DELIM_BITS + INTER_BITS + 1);

  logic          cnt_clr;
  logic          cnt_inc;
  logic [CW-1:0] cnt;
  logic          local_take;
  logic          local_ok;
  logic          sof_seen;
  ifs_state_e    state;

  ifs_seq #(
    .INTER_BITS  (INTER_BITS),
    .FLAG_BITS   (FLAG_BITS),
    .DELIM_BITS  (DELIM_BITS),
    .MAX_DOM_BITS(MAX_DOM_BITS),
    .CW          (CW)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .bit_tick  (bit_tick),
    .rx_bit    (rx_bit),
    .local_busy(local_busy),
    .local_ok  (local_ok),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .local_take(local_take),
    .sof_seen  (sof_seen),
    .state     (state),
    .sof_pulse (sof_pulse)
  );

  ifs_bit_cnt #(.W(CW)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .q    (cnt)
  );

  ifs_local_limiter #(.MAX_LOCAL(MAX_LOCAL)) lim_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sof_seen),
    .take (local_take),
    .ok   (local_ok)
  );

  assign tx_bit     = (state != S_FLAG);
  assign bus_idle   = (state == S_IDLE);
  assign ovl_active = (state == S_FLAG) || (state == S_ECHO) || (state == S_DELIM);

  // the line is driven dominant only within an overload frame (R11)
  p_dom_inside_ovl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |-> ovl_active);
  // idle and overload never overlap (R2)
  p_idle_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> (!ovl_active && tx_bit));
endmodule

// File: tb/can_ifs_ovl_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_ifs_ovl_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_end = 1'b0;
  logic bit_tick = 1'b0;
  logic rx_bit = 1'b1;
  logic local_busy = 1'b0;
  logic tx_bit, sof_pulse, bus_idle, ovl_active;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  can_ifs_ovl_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .bit_tick  (bit_tick),
    .rx_bit    (rx_bit),
    .local_busy(local_busy),
    .tx_bit    (tx_bit),
    .sof_pulse (sof_pulse),
    .bus_idle  (bus_idle),
    .ovl_active(ovl_active)
  );

  // row layout {fe, rx, busy, tx, sof, idle, ovl}
  localparam logic [6:0] VEC [32] = '{
    7'b110_1000, 7'b010_1000, 7'b010_1000, 7'b010_1010,
    7'b010_1010, 7'b000_1100, 7'b110_1000, 7'b010_1000,
    7'b010_1000, 7'b000_1100, 7'b110_1000, 7'b000_0001,
    7'b000_0001, 7'b000_0001, 7'b000_0001, 7'b000_0001,
    7'b000_0001, 7'b000_1001, 7'b000_1001, 7'b000_1001,
    7'b010_1001, 7'b010_1001, 7'b010_1001, 7'b010_1001,
    7'b010_1001, 7'b010_1001, 7'b010_1001, 7'b010_1000,
    7'b010_1000, 7'b010_1000, 7'b010_1010, 7'b000_1100
  };

  function automatic string req_of(int i);
    if (i < 5)       return "R2";
    else if (i == 5) return "R5";
    else if (i < 10) return "R4";
    else if (i < 18) return "R3";
    else if (i < 31) return "R6";
    else             return "R5";
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {tx_bit, sof_pulse, bus_idle, ovl_active};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {tx,sof,idle,ovl} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic fe, input logic rx, input logic busy,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    frame_end  = fe;
    bit_tick   = !fe;
    rx_bit     = rx;
    local_busy = busy;
    @(posedge clk);
    @(negedge clk);
    frame_end = 1'b0;
    bit_tick  = 1'b0;
    check(exp, tag);
  endtask

  // six flag ticks, one recessive start, seven more recessive, back in intermission
  task automatic ovl_body(input string tag);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 4'b0001, tag);
    step(0, 0, 0, 4'b1001, tag);
    step(0, 1, 0, 4'b1001, tag);
    for (int k = 0; k < 6; k++) step(0, 1, 0, 4'b1001, tag);
    step(0, 1, 0, 4'b1000, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(4'b1000, "R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b1000, "R1 after release");

    for (int i = 0; i < 32; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0], req_of(i));
    end

    // R3 second bit dominant, R6 twelve dominant total, R7 thirteenth abandons
    step(1, 1, 0, 4'b1000, "R3");
    step(0, 1, 0, 4'b1000, "R3");
    step(0, 0, 0, 4'b0001, "R3 second bit");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 4'b0001, "R3 flag");
    step(0, 0, 0, 4'b1001, "R3 flag end");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 4'b1001, "R6 echo");
    step(0, 0, 0, 4'b1000, "R7 thirteenth dominant");
    step(0, 1, 0, 4'b1000, "R7 waits for frame end");

    // R10 frame end ignored when idle, rx ignored without tick
    step(1, 1, 0, 4'b1000, "R10");
    step(0, 1, 0, 4'b1000, "R10");
    step(0, 1, 0, 4'b1000, "R10");
    step(0, 1, 0, 4'b1010, "R2");
    step(1, 1, 0, 4'b1010, "R10 frame end in idle");
    @(negedge clk);
    rx_bit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(4'b1010, "R10 rx without tick");
    step(0, 0, 0, 4'b1100, "R5");

    // R8 local requests capped at two
    step(1, 1, 0, 4'b1000, "R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 1, 4'b0001, "R8 first local");
    ovl_body("R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 1, 4'b0001, "R8 second local");
    ovl_body("R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 0, 4'b1000, "R8");
    step(0, 1, 1, 4'b1010, "R8 cap reached");
    step(0, 0, 0, 4'b1100, "R9 sof");

    // R9 cap cleared by start of frame
    step(1, 1, 0, 4'b1000, "R9");
    step(0, 1, 0, 4'b1000, "R9");
    step(0, 1, 0, 4'b1000, "R9");
    step(0, 1, 1, 4'b0001, "R9 local granted again");
    ovl_body("R9");

    // R7 dominant inside delimiter abandons; R11 recessive after
    step(0, 0, 0, 4'b0001, "R3");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 4'b0001, "R11");
    step(0, 0, 0, 4'b1001, "R11 flag over");
    step(0, 1, 0, 4'b1001, "R6");
    step(0, 1, 0, 4'b1001, "R6");
    step(0, 0, 0, 4'b1000, "R7 dominant in delimiter");

    finish_run();
  end
endmodule